// File: doc/BRIEF.md
# Dual Wiper Serial Control Unit

This block is the digital command path of a two-channel stepped attenuator. A host drives a three-wire serial port: an enable line that frames a transaction, a serial clock, and a data line. While the enable is high, each rising edge of the serial clock moves one data bit into a 16-bit shift register. When the enable drops after a complete frame, the register is split into two channel bytes. Each byte becomes a 7-bit wiper code from 0 to 63, or 64 when the byte's mute flag is set.

The bits pushed out of the far end of the shift register leave on a cascade output, so several units can share one data line. On a chain, each unit keeps the last 16 bits it received. An optional zero-crossing mode holds a decoded update until a strobe from an external detector arrives. If no strobe arrives, the update is applied after a timeout counted in system clocks. The serial port lines are brought into the system clock domain through synchronizer chains, and their edges are detected after synchronization.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: After reset both wiper codes are 63 and the cascade output is 0.
- R2: Frame bits are sent least significant bit first. Frame bits [7:0] drive channel 0 (`wiper0`) and bits [15:8] drive channel 1 (`wiper1`). With mute clear, the wiper code equals bits [5:0] or bits [13:8] respectively.
- R3: When bit 6 (channel 0) or bit 14 (channel 1) is 1, that wiper code becomes 64, whatever its position field holds.
- R4: Bits 7 and 15 have no effect on either wiper code.
- R5: Wiper codes do not change while the enable is high, even after 16 or more bits have been shifted in. They change only once the enable has fallen.
- R6: If the enable falls after fewer than 16 serial clock rises, the frame is discarded and both wipers keep their values.
- R7: On each serial clock rise, the bit leaving register position 0 appears on `cascade_out`. When a frame is longer than 16 bits, the last 16 bits received are applied.
- R8: With `zc_enable` low, a valid frame reaches the wipers on the third system clock edge after the enable is first sampled low.
- R9: With `zc_enable` high, a decoded update is held and is applied on the first system clock edge where `zc_strobe` is high.
- R10: With `zc_enable` high and no strobe, a held update is applied `zc_limit`+1 system clocks after it was captured.
- R11: If a new frame is captured while an update is held, and that same cycle's strobe (or timeout) releases the held update, the held update is applied and the new frame becomes the held update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Serial transaction enable (asynchronous) |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_data | input | 1 | Serial data (asynchronous) |
| zc_enable | input | 1 | Hold updates for a zero-crossing strobe |
| zc_strobe | input | 1 | Zero-crossing pulse, synchronous to clk |
| zc_limit | input | TMO_W | Timeout in system clocks for a held update |
| wiper0 | output | POS_W+1 | Channel 0 wiper code, 0..64 |
| wiper1 | output | POS_W+1 | Channel 1 wiper code, 0..64 |
| cascade_out | output | 1 | Bit shifted out of register position 0 |

## Verification
Two events can fall on the same system clock edge. One is the capture of a fresh frame at enable fall. The other is the release of an older held update by the zero-crossing strobe. The bench provokes this by asserting the strobe exactly on the capture edge while an earlier frame is pending. It then judges the outcome against its cycle model: the older value must appear at once, and the newer one only at the next strobe. The model tracks synchronizer latency, shifting, cascade and gating every clock, so the wipers and cascade are compared on every cycle.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_FRAME = 2'd1,
      ACT_HELD  = 2'd2
   } dwc_act_e;

endpackage

// File: rtl/dwc_sync.sv
module dwc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dwc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dwc_shifter.sv
module dwc_shifter #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               s_clk,
   input  logic               s_en,
   input  logic               s_dat,
   output logic               frame_ok,
   output logic [FRAME_W-1:0] frame,
   output logic               cascade
);
   localparam int CNT_W = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

   logic               clk_q, en_q;
   logic [FRAME_W-1:0] sr;
   logic [CNT_W-1:0]   cnt;
   logic               casc;
   logic               shift, en_rise, en_fall;

   assign shift   = s_clk & ~clk_q & s_en;
   assign en_rise = s_en & ~en_q;
   assign en_fall = ~s_en & en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_q <= 1'b0;
         en_q  <= 1'b0;
      end else begin
         clk_q <= s_clk;
         en_q  <= s_en;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         casc <= 1'b0;
      end else if (shift) begin
         sr   <= {s_dat, sr[FRAME_W-1:1]};
         casc <= sr[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (en_rise)
         cnt <= shift ? CNT_W'(1) : '0;
      else if (shift && cnt != FULL)
         cnt <= cnt + CNT_W'(1);
   end

   assign frame_ok = en_fall && (cnt == FULL);
   assign frame    = sr;
   assign cascade  = casc;

   p_count_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL);
   p_cascade_r7: assert property (@(posedge clk) disable iff (!rst_n)
      shift |=> cascade == $past(sr[0]));
endmodule

// File: rtl/dwc_gate.sv
module dwc_gate
   import dwc_pkg::*;
#(
   parameter int FRAME_W    = 16,
   parameter int TMO_W      = 16,
   parameter bit ZC_SUPPORT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_ok,
   input  logic [FRAME_W-1:0] frame,
   input  logic               zc_en,
   input  logic               zc_strobe,
   input  logic [TMO_W-1:0]   zc_limit,
   output logic               apply,
   output logic [FRAME_W-1:0] apply_word
);
   if (ZC_SUPPORT) begin : g_zc
      logic               pend, pend_n;
      logic [FRAME_W-1:0] held, held_n;
      logic [TMO_W-1:0]   tmr, tmr_n;
      logic               release_now;
      dwc_act_e           act;

      assign release_now = pend && (zc_strobe || tmr == zc_limit);

      always_comb begin
         act    = ACT_NONE;
         pend_n = pend;
         held_n = held;
         tmr_n  = tmr;
         if (frame_ok) begin
            if (!zc_en) begin
               act    = ACT_FRAME;
               pend_n = 1'b0;
            end else begin
               if (release_now) act = ACT_HELD;
               pend_n = 1'b1;
               held_n = frame;
               tmr_n  = '0;
            end
         end else if (pend) begin
            if (!zc_en || release_now) begin
               act    = ACT_HELD;
               pend_n = 1'b0;
            end else begin
               tmr_n = tmr + TMO_W'(1);
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend <= 1'b0;
            held <= '0;
            tmr  <= '0;
         end else begin
            pend <= pend_n;
            held <= held_n;
            tmr  <= tmr_n;
         end
      end

      assign apply      = (act != ACT_NONE);
      assign apply_word = (act == ACT_FRAME) ? frame : held;

      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (pend && zc_en && !zc_strobe && !frame_ok && tmr != zc_limit)
            |=> (pend && $stable(held)));
      p_new_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (frame_ok && zc_en) |=> (pend && held == $past(frame)));
   end else begin : g_direct
      assign apply      = frame_ok;
      assign apply_word = frame;
   end
endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl #(
   parameter int SYNC_STAGES = 2,
   parameter int FIELD_W     = 8,
   parameter int POS_W       = 6,
   parameter int TMO_W       = 16,
   parameter bit ZC_SUPPORT  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_en,
   input  logic             ser_clk,
   input  logic             ser_data,
   input  logic             zc_enable,
   input  logic             zc_strobe,
   input  logic [TMO_W-1:0] zc_limit,
   output logic [POS_W:0]   wiper0,
   output logic [POS_W:0]   wiper1,
   output logic             cascade_out
);
   localparam int NUM_CH  = 2;
   localparam int FRAME_W = NUM_CH * FIELD_W;
   localparam int WIPER_W = POS_W + 1;
   localparam logic [WIPER_W-1:0] MUTE_CODE  = WIPER_W'(1) << POS_W;
   localparam logic [WIPER_W-1:0] RESET_CODE = MUTE_CODE - WIPER_W'(1);

   if (FIELD_W < POS_W + 2) begin : g_bad_field
      $error("dual_wiper_ctrl: FIELD_W must hold position, mute and spare bit");
   end

   logic s_clk, s_en, s_dat;
   logic frame_ok, apply;
   logic [FRAME_W-1:0] frame, apply_word;

   dwc_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d(ser_clk), .q(s_clk));
   dwc_sync #(.STAGES(SYNC_STAGES)) u_sync_en (
      .clk(clk), .rst_n(rst_n), .d(ser_en), .q(s_en));
   dwc_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .d(ser_data), .q(s_dat));

   dwc_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .s_clk(s_clk), .s_en(s_en), .s_dat(s_dat),
      .frame_ok(frame_ok), .frame(frame), .cascade(cascade_out));

   dwc_gate #(.FRAME_W(FRAME_W), .TMO_W(TMO_W), .ZC_SUPPORT(ZC_SUPPORT)) u_gate (
      .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .frame(frame),
      .zc_en(zc_enable), .zc_strobe(zc_strobe), .zc_limit(zc_limit),
      .apply(apply), .apply_word(apply_word));

   logic [WIPER_W-1:0] wip [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [FIELD_W-1:0] fld;
      logic [WIPER_W-1:0] code;
      assign fld  = apply_word[c*FIELD_W +: FIELD_W];
      assign code = fld[POS_W] ? MUTE_CODE : {1'b0, fld[POS_W-1:0]};
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     wip[c] <= RESET_CODE;
         else if (apply) wip[c] <= code;
      end
   end

   assign wiper0 = wip[0];
   assign wiper1 = wip[1];

   p_wiper_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !apply |=> ($stable(wiper0) && $stable(wiper1)));
   p_mute_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && apply_word[POS_W]) |=> wiper0 == MUTE_CODE);
   p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wiper0 <= MUTE_CODE) && (wiper1 <= MUTE_CODE));
endmodule

// File: tb/tb_dual_wiper_ctrl.sv
module tb_dual_wiper_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_en = 1'b0, ser_clk = 1'b0, ser_data = 1'b0;
   logic        zc_enable = 1'b0, zc_strobe = 1'b0;
   logic [15:0] zc_limit = 16'd1000;
   logic [6:0]  wiper0, wiper1;
   logic        cascade_out;

   int n_cmp = 0, n_bad = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   dual_wiper_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
      .ser_data(ser_data), .zc_enable(zc_enable), .zc_strobe(zc_strobe),
      .zc_limit(zc_limit), .wiper0(wiper0), .wiper1(wiper1),
      .cascade_out(cascade_out));

   // behavioural reference: input history queues, bit list, pending slot
   bit   hq_ck[$], hq_en[$], hq_d[$];
   bit   m_bits[$];
   int   m_cnt, m_w0, m_w1, m_tmr;
   bit   m_casc, m_pend;
   int   m_held;

   function automatic int dec(int byte_v);
      if ((byte_v >> 6) & 1) return 64;
      return byte_v & 63;
   endfunction

   function automatic int bits_word();
      int w = 0;
      for (int i = 0; i < 16; i++) if (m_bits[i]) w |= (1 << i);
      return w;
   endfunction

   task automatic model_apply(int w);
      m_w0 = dec(w & 255);
      m_w1 = dec((w >> 8) & 255);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         hq_ck = {0, 0, 0}; hq_en = {0, 0, 0}; hq_d = {0, 0, 0};
         m_bits = {};
         for (int i = 0; i < 16; i++) m_bits.push_back(0);
         m_cnt = 0; m_w0 = 63; m_w1 = 63; m_casc = 0; m_pend = 0; m_held = 0; m_tmr = 0;
      end else begin
         // index 1 = two edges back, index 2 = three edges back
         bit sh, up, dn, fok, rel;
         sh  = hq_ck[1] && !hq_ck[2] && hq_en[1];
         up  = hq_en[1] && !hq_en[2];
         dn  = !hq_en[1] && hq_en[2];
         fok = dn && (m_cnt == 16);
         rel = m_pend && (zc_strobe || m_tmr == int'(zc_limit));
         if (fok && !zc_enable) begin
            model_apply(bits_word()); m_pend = 0;
         end else if (fok) begin
            if (rel) model_apply(m_held);
            m_pend = 1; m_held = bits_word(); m_tmr = 0;
         end else if (m_pend) begin
            if (!zc_enable || rel) begin model_apply(m_held); m_pend = 0; end
            else m_tmr = (m_tmr + 1) & 16'hffff;
         end
         if (sh) begin
            m_casc = m_bits.pop_front();
            m_bits.push_back(hq_d[1]);
         end
         if (up) m_cnt = sh ? 1 : 0;
         else if (sh && m_cnt < 16) m_cnt++;
         hq_ck.push_front(ser_clk);  void'(hq_ck.pop_back());
         hq_en.push_front(ser_en);   void'(hq_en.pop_back());
         hq_d.push_front(ser_data);  void'(hq_d.pop_back());
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         n_cmp++;
         if (int'(wiper0) != m_w0 || int'(wiper1) != m_w1 || cascade_out != m_casc) begin
            n_bad++;
            $display("FAIL %s per-cycle: w0=%0d w1=%0d casc=%0b expected w0=%0d w1=%0d casc=%0b",
                     cur_req, wiper0, wiper1, cascade_out, m_w0, m_w1, m_casc);
         end
      end
   end

   task automatic chk(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic send(logic [31:0] v, int n, bit drop, bit strobe_cap);
      ser_en = 1'b1; cyc(4);
      for (int i = 0; i < n; i++) begin
         ser_data = v[i]; cyc(4);
         ser_clk = 1'b1; cyc(4);
         ser_clk = 1'b0;
      end
      cyc(4);
      if (drop) begin
         ser_en = 1'b0;
         if (strobe_cap) begin
            cyc(2); zc_strobe = 1'b1; cyc(1); zc_strobe = 1'b0; cyc(5);
         end else cyc(8);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      cyc(3); rst_n = 1'b1; cyc(2);
      cur_req = "R1";
      chk("R1 wiper0", wiper0, 63); chk("R1 wiper1", wiper1, 63); chk("R1 cascade", cascade_out, 0);

      cur_req = "R2/R8";
      send({16'h0, 8'd40, 8'd5}, 16, 1, 0);
      chk("R2 wiper0", wiper0, 5); chk("R8 wiper1", wiper1, 40);

      cur_req = "R3/R4";
      send({16'h0, 8'h91, 8'h6A}, 16, 1, 0);
      chk("R3 wiper0 mute", wiper0, 64); chk("R4 wiper1 bit15", wiper1, 17);
      send({16'h0, 8'hD5, 8'h80}, 16, 1, 0);
      chk("R4 wiper0 bit7", wiper0, 0); chk("R3 wiper1 mute", wiper1, 64);

      cur_req = "R5";
      send({16'h0, 8'd9, 8'd33}, 16, 0, 0);
      chk("R5 wiper0 held", wiper0, 0); chk("R5 wiper1 held", wiper1, 64);
      ser_en = 1'b0; cyc(8);
      chk("R5 wiper0 after fall", wiper0, 33); chk("R5 wiper1 after fall", wiper1, 9);

      cur_req = "R6";
      send({16'h0, 16'h0A0B}, 10, 1, 0);
      chk("R6 wiper0", wiper0, 33); chk("R6 wiper1", wiper1, 9);

      cur_req = "R7";
      send({8'h0, 8'd21, 8'd12, 8'h8E}, 24, 1, 0);
      chk("R7 wiper0", wiper0, 12); chk("R7 wiper1", wiper1, 21);
      chk("R7 cascade", cascade_out, 1);

      cur_req = "R9";
      zc_enable = 1'b1; zc_limit = 16'd1000;
      send({16'h0, 8'd3, 8'd7}, 16, 1, 0);
      cyc(20);
      chk("R9 wiper0 pending", wiper0, 12);
      zc_strobe = 1'b1; cyc(1); zc_strobe = 1'b0; cyc(1);
      chk("R9 wiper0 released", wiper0, 7); chk("R9 wiper1 released", wiper1, 3);

      cur_req = "R10";
      zc_limit = 16'd20;
      send({16'h0, 8'd50, 8'd60}, 16, 1, 0);
      chk("R10 wiper0 before timeout", wiper0, 7);
      cyc(30);
      chk("R10 wiper0 timeout", wiper0, 60); chk("R10 wiper1 timeout", wiper1, 50);

      cur_req = "R11";
      zc_limit = 16'd1000;
      send({16'h0, 8'd1, 8'd2}, 16, 1, 0);
      send({16'h0, 8'd44, 8'd55}, 16, 1, 1);
      chk("R11 old applied w0", wiper0, 2); chk("R11 old applied w1", wiper1, 1);
      cyc(10);
      chk("R11 new still held", wiper0, 2);
      zc_strobe = 1'b1; cyc(1); zc_strobe = 1'b0; cyc(1);
      chk("R11 new applied w0", wiper0, 55); chk("R11 new applied w1", wiper1, 44);

      cur_req = "R8";
      zc_enable = 1'b0;
      send({16'h0, 8'd62, 8'd0}, 16, 1, 0);
      chk("R8 immediate w0", wiper0, 0); chk("R8 immediate w1", wiper1, 62);

      cyc(4);
      finish_run();
   end
endmodule